// File: doc/BRIEF.md
# Link Lane Status Evaluator

This block interprets a six-byte status snapshot that a link controller has read back from a DisplayPort sink during link training. It does not fetch the bytes and it makes no training decisions. It only turns the raw snapshot into per-lane status nibbles and two verdicts. The first verdict says whether clock recovery has completed on every active lane. The second says whether channel equalization, symbol lock and inter-lane alignment have all been reached.

A one-cycle `stat_valid` strobe presents the snapshot and the active lane count. The block captures both on that edge. The verdicts, the nibbles and a one-cycle `res_done` pulse follow on the next edge. Lanes at or above the active lane count play no part in the verdicts and are reported as zero. The results hold until the next strobe.

Top module: `link_lane_status_eval`

## Requirements
- R1: After reset, and while reset is held, `lane_nib`, `cr_ok`, `eq_ok` and `res_done` are all zero.
- R2: Lane n's status nibble is taken from snapshot byte n>>1, which sits at `stat_bytes[8*(n>>1)+7 : 8*(n>>1)]`. Even lanes use bits 3:0 and odd lanes use bits 7:4. The nibble appears on `lane_nib[4n+3:4n]`.
- R3: A lane whose index is at or above the active lane count is reported on `lane_nib` as 0000, whatever its snapshot bits hold.
- R4: `cr_ok` is 1 only when nibble bit 0 (clock recovery done) is set on every active lane.
- R5: `eq_ok` is 1 only when bit 0 of snapshot byte 2 (inter-lane alignment done) is set and every active lane has nibble bits 0, 1 and 2 set (bit 1 is equalization done, bit 2 is symbol locked). `eq_ok` is never 1 while `cr_ok` is 0.
- R6: Snapshot bytes 3 to 5, and bits 7:1 of byte 2, have no effect on any output.
- R7: A lane count other than 1, 2 or 4 (0, 3, 5, 6 or 7 on the 3-bit `lane_cnt`) forces `cr_ok` and `eq_ok` low and all of `lane_nib` to zero.
- R8: A strobe sampled at clock edge k updates the outputs at edge k+1. `res_done` is high for exactly the cycle after edge k+1. Strobes on consecutive cycles give results and `res_done` on consecutive cycles.
- R9: While `stat_valid` is low, changes on `stat_bytes` and `lane_cnt` leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_valid | input | 1 | Strobe: capture the snapshot and lane count on this edge |
| stat_bytes | input | 48 | Status snapshot; byte k is bits 8k+7:8k |
| lane_cnt | input | 3 | Active lane count; 1, 2 or 4 are supported |
| lane_nib | output | 16 | Per-lane status nibbles, lane n at bits 4n+3:4n |
| cr_ok | output | 1 | Clock recovery done on all active lanes |
| eq_ok | output | 1 | Equalization, symbol lock and alignment done |
| res_done | output | 1 | One-cycle pulse marking fresh results |

## Verification
The bench aims at the lane-to-nibble mapping. A design that swapped the halves of a byte, or read lanes 2 and 3 from the wrong byte, would report misplaced nibbles and wrong verdicts on the four-lane vectors.

It presents inactive lanes carrying failing bits under one-lane and two-lane counts. A design that forgot the lane mask would then drop `cr_ok` or `eq_ok`, or leak those nibbles onto the output. Unsupported counts 0, 3 and 7 are applied with an otherwise passing snapshot, so treating 3 as "three lanes" would wrongly raise both flags.

Vectors that lack only the alignment bit, only symbol lock, or only the equalization bit catch an equalization check that tests too few bits. Garbage driven on the inputs while the strobe is low, together with back-to-back strobes, exposes outputs that track the live inputs or a done pulse that is stretched or lost.

// File: rtl/lsev_pkg.sv
package lsev_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  // nibble bit meanings
  localparam int NB_CR   = 0;
  localparam int NB_EQ   = 1;
  localparam int NB_LOCK = 2;

  // a count is usable when it is a non-zero power of two not above the lane budget
  function automatic logic count_supported(input int unsigned cnt,
                                           input int unsigned max_lanes);
    return (cnt != 0) && (cnt <= max_lanes) && ((cnt & (cnt - 1)) == 0);
  endfunction

  function automatic logic lane_is_active(input int unsigned cnt,
                                          input int unsigned lane,
                                          input int unsigned max_lanes);
    return count_supported(cnt, max_lanes) && (lane < cnt);
  endfunction

  // all three per-lane completion bits present
  function automatic logic lane_eq_complete(input logic [NIB_W-1:0] nib);
    return nib[NB_CR] & nib[NB_EQ] & nib[NB_LOCK];
  endfunction

endpackage

// File: rtl/lsev_capture.sv
module lsev_capture #(
  parameter int SNAP_W = 48,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [SNAP_W-1:0] stat_bytes,
  input  logic [CNT_W-1:0]  lane_cnt,
  output logic [SNAP_W-1:0] snap_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cap_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q    <= '0;
      cnt_q     <= '0;
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= stat_valid;
      if (stat_valid) begin
        snap_q <= stat_bytes;
        cnt_q  <= lane_cnt;
      end
    end
  end

  // R8: a strobe always produces a capture marker on the following cycle
  assert_capture_follows_strobe_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    stat_valid |=> cap_valid);

  // R9: without a strobe the captured snapshot stays put
  assert_snapshot_held_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    !stat_valid |=> ($stable(snap_q) && $stable(cnt_q)));

endmodule

// File: rtl/lsev_lane_slice.sv
module lsev_lane_slice
  import lsev_pkg::*;
(
  input  logic [NIB_W-1:0] raw_nib,
  input  logic             active,
  output logic [NIB_W-1:0] shown_nib,
  output logic             cr_pass,
  output logic             eq_pass
);

  // inactive lanes read as zero and never veto a verdict
  always_comb begin
    if (active) begin
      shown_nib = raw_nib;
      cr_pass   = raw_nib[NB_CR];
      eq_pass   = lane_eq_complete(raw_nib);
    end else begin
      shown_nib = '0;
      cr_pass   = 1'b1;
      eq_pass   = 1'b1;
    end
  end

endmodule

// File: rtl/lsev_verdict.sv
module lsev_verdict
  import lsev_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_valid,
  input  logic                       cnt_ok,
  input  logic                       align_done,
  input  logic [MAX_LANES-1:0]       cr_vec,
  input  logic [MAX_LANES-1:0]       eq_vec,
  input  logic [MAX_LANES*NIB_W-1:0] nib_vec,
  output logic [MAX_LANES*NIB_W-1:0] lane_nib,
  output logic                       cr_ok,
  output logic                       eq_ok,
  output logic                       res_done
);

  logic cr_next;
  logic eq_next;

  assign cr_next = cnt_ok & (&cr_vec);
  assign eq_next = cr_next & align_done & (&eq_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_nib <= '0;
      cr_ok    <= 1'b0;
      eq_ok    <= 1'b0;
      res_done <= 1'b0;
    end else begin
      res_done <= cap_valid;
      if (cap_valid) begin
        lane_nib <= nib_vec;
        cr_ok    <= cr_next;
        eq_ok    <= eq_next;
      end
    end
  end

  // R5: equalization can only be reported once clock recovery is reported
  assert_eq_needs_cr_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    eq_ok |-> cr_ok);

  // R8: done is high exactly one cycle after each capture
  assert_done_tracks_capture_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    cap_valid |=> res_done);

  assert_done_only_after_capture_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    !cap_valid |=> !res_done);

  // R9: results hold while nothing new has been captured
  assert_results_held_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    !cap_valid |=> ($stable(cr_ok) && $stable(eq_ok) && $stable(lane_nib)));

  // R7: an unusable lane count clears both verdicts and every nibble
  assert_bad_count_clears_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cap_valid && !cnt_ok) |=> (!cr_ok && !eq_ok && (lane_nib == '0)));

  // R5: a missing alignment bit blocks the equalization verdict
  assert_align_gates_eq_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cap_valid && !align_done) |=> !eq_ok);

endmodule

// File: rtl/link_lane_status_eval.sv
module link_lane_status_eval
  import lsev_pkg::*;
#(
  parameter int MAX_LANES  = 4,
  parameter int SNAP_BYTES = 6,
  parameter int ALIGN_BYTE = 2,
  parameter int ALIGN_BIT  = 0,
  localparam int SNAP_W    = SNAP_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(MAX_LANES) + 1,
  localparam int NIBS_W    = MAX_LANES * NIB_W,
  localparam int LANE_BYTES = (MAX_LANES + 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [SNAP_W-1:0] stat_bytes,
  input  logic [CNT_W-1:0]  lane_cnt,
  output logic [NIBS_W-1:0] lane_nib,
  output logic              cr_ok,
  output logic              eq_ok,
  output logic              res_done
);

  logic [SNAP_W-1:0]    snap_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 cap_valid;
  logic                 cnt_ok;
  logic                 align_done;
  logic [MAX_LANES-1:0] cr_vec;
  logic [MAX_LANES-1:0] eq_vec;
  logic [NIBS_W-1:0]    nib_vec;
  logic                 unused_snap;

  lsev_capture #(
    .SNAP_W (SNAP_W),
    .CNT_W  (CNT_W)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_valid (stat_valid),
    .stat_bytes (stat_bytes),
    .lane_cnt   (lane_cnt),
    .snap_q     (snap_q),
    .cnt_q      (cnt_q),
    .cap_valid  (cap_valid)
  );

  assign cnt_ok     = count_supported(int'(cnt_q), MAX_LANES);
  assign align_done = snap_q[ALIGN_BYTE*BYTE_W + ALIGN_BIT];

  // bits outside the lane bytes and the alignment flag carry nothing for this block
  assign unused_snap = ^{snap_q[SNAP_W-1:LANE_BYTES*BYTE_W] &
                         ~({(SNAP_W-LANE_BYTES*BYTE_W){1'b0}} |
                           (SNAP_W-LANE_BYTES*BYTE_W)'(1) << ((ALIGN_BYTE-LANE_BYTES)*BYTE_W + ALIGN_BIT))};

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    localparam int BYTE_IX = g / 2;
    localparam int SHIFT   = (g % 2) * NIB_W;
    logic [NIB_W-1:0] raw;
    logic             active;

    assign raw    = snap_q[BYTE_IX*BYTE_W + SHIFT +: NIB_W];
    assign active = lane_is_active(int'(cnt_q), g, MAX_LANES);

    lsev_lane_slice u_slice (
      .raw_nib   (raw),
      .active    (active),
      .shown_nib (nib_vec[g*NIB_W +: NIB_W]),
      .cr_pass   (cr_vec[g]),
      .eq_pass   (eq_vec[g])
    );
  end

  lsev_verdict #(
    .MAX_LANES (MAX_LANES)
  ) u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_valid  (cap_valid),
    .cnt_ok     (cnt_ok),
    .align_done (align_done),
    .cr_vec     (cr_vec),
    .eq_vec     (eq_vec),
    .nib_vec    (nib_vec),
    .lane_nib   (lane_nib),
    .cr_ok      (cr_ok),
    .eq_ok      (eq_ok),
    .res_done   (res_done)
  );

  // R3: with a single active lane only lane 0 may show a non-zero nibble
  assert_single_lane_masks_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cap_valid && (cnt_q == CNT_W'(1))) |=> (lane_nib[NIBS_W-1:NIB_W] == '0));

  // R2: lane 0 reports the low half of the first captured byte
  assert_lane0_mapping_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cap_valid && cnt_ok) |=> (lane_nib[NIB_W-1:0] == $past(snap_q[NIB_W-1:0])));

  // R4: a lane 0 without clock recovery blocks the recovery verdict
  assert_lane0_cr_gate_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cap_valid && !snap_q[NB_CR]) |=> !cr_ok);

endmodule

// File: tb/link_lane_status_eval_tb.sv
`timescale 1ns/1ps
module link_lane_status_eval_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_valid = 1'b0;
  logic [47:0] stat_bytes = '0;
  logic [2:0]  lane_cnt = '0;
  logic [15:0] lane_nib;
  logic        cr_ok;
  logic        eq_ok;
  logic        res_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  link_lane_status_eval u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_valid (stat_valid),
    .stat_bytes (stat_bytes),
    .lane_cnt   (lane_cnt),
    .lane_nib   (lane_nib),
    .cr_ok      (cr_ok),
    .eq_ok      (eq_ok),
    .res_done   (res_done)
  );

  // {lane count, bytes 5..0, expected cr, expected eq}
  localparam int NV = 16;
  localparam logic [52:0] VEC [NV] = '{
    {3'd4, 48'hAAAAAA017777, 1'b1, 1'b1},  // R5 all done, R6 junk in bytes 3-5
    {3'd4, 48'h000000007777, 1'b1, 1'b0},  // R5 alignment missing
    {3'd4, 48'h000000013777, 1'b1, 1'b0},  // R2 lane 3 lacks lock (byte1 high)
    {3'd4, 48'h000000016777, 1'b0, 1'b0},  // R4 lane 3 lacks cr
    {3'd2, 48'h000000010077, 1'b1, 1'b1},  // R3 lanes 2,3 ignored
    {3'd1, 48'h000000010007, 1'b1, 1'b1},  // R3 lane 1 ignored
    {3'd1, 48'hFFFFFFFEFFF1, 1'b1, 1'b0},  // R5 align bit 0 clear
    {3'd2, 48'hFFFFFFFF001F, 1'b1, 1'b0},  // R2 lane 1 from byte0 high half
    {3'd3, 48'h000000017777, 1'b0, 1'b0},  // R7 count 3
    {3'd0, 48'h000000017777, 1'b0, 1'b0},  // R7 count 0
    {3'd2, 48'h0000000100E7, 1'b0, 1'b0},  // R4 lane 1 lacks cr
    {3'd4, 48'h000000017777, 1'b1, 1'b1},  // R5 clean pass
    {3'd4, 48'h000000FF7777, 1'b1, 1'b1},  // R6 upper align bits ignored
    {3'd7, 48'h000000017777, 1'b0, 1'b0},  // R7 count 7
    {3'd1, 48'h000000010005, 1'b1, 1'b0},  // R5 eq bit missing
    {3'd1, 48'h000000010003, 1'b1, 1'b0}   // R5 lock bit missing
  };

  function automatic logic [15:0] model_nibs(input logic [2:0] cnt, input logic [47:0] b);
    logic [15:0] r = '0;
    bit ok = (cnt == 3'd1) || (cnt == 3'd2) || (cnt == 3'd4);
    for (int l = 0; l < 4; l++) begin
      logic [7:0] by = b[8*(l/2) +: 8];
      if (ok && l < int'(cnt))
        r[4*l +: 4] = (l % 2 == 1) ? by[7:4] : by[3:0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic apply(input logic [2:0] cnt, input logic [47:0] b,
                       input bit ecr, input bit eeq);
    logic [15:0] en = model_nibs(cnt, b);
    @(negedge clk);
    stat_valid = 1'b1; stat_bytes = b; lane_cnt = cnt;
    @(negedge clk);
    stat_valid = 1'b0; stat_bytes = ~b; lane_cnt = 3'd4;  // R9 garbage while idle
    @(negedge clk);
    check(res_done == 1'b1, "R8 done pulse", 16'(res_done), 16'd1);
    check(lane_nib == en, "R2/R3 nibbles", lane_nib, en);
    check(cr_ok == ecr, "R4 cr_ok", 16'(cr_ok), 16'(ecr));
    check(eq_ok == eeq, "R5 eq_ok", 16'(eq_ok), 16'(eeq));
    @(negedge clk);
    check(res_done == 1'b0, "R8 done one cycle", 16'(res_done), 16'd0);
    check(lane_nib == en && cr_ok == ecr && eq_ok == eeq, "R9 results held",
          {lane_nib[13:0], cr_ok, eq_ok}, {en[13:0], ecr, eeq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check(lane_nib == 16'h0 && !cr_ok && !eq_ok && !res_done, "R1 reset held",
          {lane_nib[12:0], cr_ok, eq_ok, res_done}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lane_nib == 16'h0 && !cr_ok && !eq_ok && !res_done, "R1 after reset",
          {lane_nib[12:0], cr_ok, eq_ok, res_done}, 16'h0);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][52:50], VEC[i][49:2], VEC[i][1], VEC[i][0]);

    // R8: back-to-back strobes give consecutive results
    @(negedge clk);
    stat_valid = 1'b1; lane_cnt = 3'd4; stat_bytes = 48'h000000017777;
    @(negedge clk);
    stat_bytes = 48'h000000016777;
    @(negedge clk);
    stat_valid = 1'b0;
    check(res_done && cr_ok && eq_ok, "R8 first of pair",
          {13'd0, res_done, cr_ok, eq_ok}, 16'h7);
    @(negedge clk);
    check(res_done && !cr_ok && !eq_ok && lane_nib == 16'h6777, "R8 second of pair",
          lane_nib, 16'h6777);
    @(negedge clk);
    check(!res_done, "R8 pair ends", 16'(res_done), 16'd0);

    // R9: long idle with churning inputs
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      stat_bytes = {8{6'(k)}}; lane_cnt = 3'(k);
    end
    @(negedge clk);
    check(!res_done && !cr_ok && lane_nib == 16'h6777, "R9 idle churn",
          lane_nib, 16'h6777);

    // R1: reset in the middle of operation clears results
    @(negedge clk);
    stat_valid = 1'b1; lane_cnt = 3'd4; stat_bytes = 48'h000000017777;
    @(negedge clk);
    stat_valid = 1'b0;
    @(negedge clk);
    check(cr_ok && eq_ok, "R5 before reset", {14'd0, cr_ok, eq_ok}, 16'h3);
    rst_n = 1'b0;
    @(negedge clk);
    check(lane_nib == 16'h0 && !cr_ok && !eq_ok && !res_done, "R1 mid-run reset",
          lane_nib, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule